// File: doc/BRIEF.md
# Packed Lane Integer Add, Compare and Byte-Difference Unit

This unit treats each of two 64-bit source words as a row of packed integer lanes and produces one 64-bit result per accepted request. The lanes can be bytes, halfwords or words. It supports four operations on those lanes:

- add and subtract, which either wrap or clamp under one of three saturation modes;
- equality compare;
- signed greater-than compare.

Each compare paints its lane with all ones or all zeros. A fifth operation adds up the absolute differences of the eight unsigned byte pairs into one scalar.

A request is offered with a valid strobe and a qualifying predicate. The result register loads on the clock edge where both are high and the operation and lane-size codes are legal. In every other cycle the register holds its old value, so a false predicate behaves as a squashed write to a destination register. All lane logic is combinational. The only state is the result register.

Top module: `simd_alu`

## Requirements
- R1: The lane-size code selects 8 byte lanes (0), 4 halfword lanes (1) or 2 word lanes (2). No carry, borrow or clamp crosses a lane boundary.
- R2: With saturation code 0, add (op 0) and subtract (op 1) wrap modulo 2^lane-width in every lane.
- R3: With saturation code 1, the result and both sources are signed. A byte lane clamps to 0x80..0x7F and a halfword lane clamps to 0x8000..0x7FFF.
- R4: With saturation code 2, the result and the first source are unsigned and the second source is signed. The lane clamps to 0..all-ones.
- R5: With saturation code 3, the result and both sources are unsigned. The lane clamps to 0..all-ones.
- R6: Word lanes (size code 2) always wrap modulo 2^32, whatever the saturation code.
- R7: Op 2 compares lanes for equality. A true lane becomes all ones and a false lane becomes all zeros.
- R8: Op 3 compares lanes as signed two's-complement values, first source greater than second. It produces the same all-ones or all-zeros lane masks.
- R9: Op 4 sums the absolute differences of the 8 unsigned byte pairs. The sum is zero-extended to 64 bits, and the lane-size and saturation codes have no effect on it.
- R10: When valid or predicate is low, the result register keeps its previous value.
- R11: Op codes 5..7 and lane-size code 3 are reserved. A request using them leaves the result register unchanged.
- R12: Reset (rst_n low, asynchronous) clears the result to zero. An accepted request shows at result_o after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| pred_i | input | 1 | Qualifying predicate; 0 squashes the write |
| op_i | input | 3 | 0 add, 1 sub, 2 compare-equal, 3 compare-greater signed, 4 byte abs-diff sum |
| lsize_i | input | 2 | 0 byte, 1 halfword, 2 word lanes |
| sat_i | input | 2 | 0 wrap, 1 all signed, 2 unsigned/unsigned/signed, 3 all unsigned |
| src_a_i | input | 64 | First packed source |
| src_b_i | input | 64 | Second packed source |
| result_o | output | 64 | Registered result |

## Verification
The bench builds the block with its default 64-bit data width, which is the only width the lane structure is meant for.

Across the add, subtract and compare sweeps:
- each byte position of the first source steps through all 256 values;
- the second source is seeded from boundary values (0x00, 0x01, 0x7F, 0x80, 0xFF) or is an exact copy of the first.

Together these reach every clamp edge of the three saturation modes, the wrap point of each lane size, and both outcomes of each compare. Expected words are computed arithmetically per lane in the bench. Directed cases cover the predicate, the reserved codes and reset.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int DATA_W = 64;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CEQ = 3'd2,
        OP_CGT = 3'd3,
        OP_SAD = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        LW_B = 2'd0,
        LW_H = 2'd1,
        LW_W = 2'd2
    } lw_e;

    typedef enum logic [1:0] {
        SAT_WRAP = 2'd0,
        SAT_SSS  = 2'd1,
        SAT_UUS  = 2'd2,
        SAT_UUU  = 2'd3
    } sat_e;
endpackage

// File: rtl/simd_lane.sv
// One lane of add/subtract with optional clamping, plus compare flags.
module simd_lane
    import simd_pkg::*;
#(
    parameter int W      = 8,
    parameter bit SAT_EN = 1'b1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic [1:0]   sat_i,
    output logic [W-1:0] sum_o,
    output logic         eq_o,
    output logic         gt_o
);
    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] S_MAX = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] S_MIN = {3'b111, {(W-1){1'b0}}};
    localparam logic signed [XW-1:0] U_MAX = {2'b00, {W{1'b1}}};

    logic                 a_sgn, b_sgn, r_sgn;
    logic signed [XW-1:0] ax, bx, rx;
    logic [W-1:0]         clamp;

    always_comb begin
        r_sgn = (sat_i == SAT_SSS);
        a_sgn = r_sgn;
        b_sgn = (sat_i == SAT_SSS) || (sat_i == SAT_UUS);

        ax = a_sgn ? {{2{a_i[W-1]}}, a_i} : {2'b00, a_i};
        bx = b_sgn ? {{2{b_i[W-1]}}, b_i} : {2'b00, b_i};
        rx = sub_i ? (ax - bx) : (ax + bx);

        if (r_sgn) begin
            if (rx > S_MAX)      clamp = S_MAX[W-1:0];
            else if (rx < S_MIN) clamp = S_MIN[W-1:0];
            else                 clamp = rx[W-1:0];
        end else begin
            if (rx[XW-1])        clamp = '0;
            else if (rx > U_MAX) clamp = U_MAX[W-1:0];
            else                 clamp = rx[W-1:0];
        end

        sum_o = (SAT_EN && (sat_i != SAT_WRAP)) ? clamp : rx[W-1:0];
    end

    assign eq_o = (a_i == b_i);
    assign gt_o = ($signed(a_i) > $signed(b_i));
endmodule

// File: rtl/simd_sad.sv
// Sum of absolute differences over NB unsigned byte pairs.
module simd_sad #(
    parameter int NB = 8,
    parameter int SW = 11
) (
    input  logic [NB*8-1:0] a_i,
    input  logic [NB*8-1:0] b_i,
    output logic [SW-1:0]   sad_o
);
    function automatic logic [7:0] absd(input logic [7:0] x, input logic [7:0] y);
        return (x > y) ? (x - y) : (y - x);
    endfunction

    always_comb begin
        sad_o = '0;
        for (int k = 0; k < NB; k++) begin
            sad_o = sad_o + SW'(absd(a_i[k*8 +: 8], b_i[k*8 +: 8]));
        end
    end
endmodule

// File: rtl/simd_alu.sv
// Packed lane integer add/sub/compare/abs-diff-sum unit, one registered result.
module simd_alu
    import simd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          pred_i,
    input  logic [2:0]    op_i,
    input  logic [1:0]    lsize_i,
    input  logic [1:0]    sat_i,
    input  logic [DW-1:0] src_a_i,
    input  logic [DW-1:0] src_b_i,
    output logic [DW-1:0] result_o
);
    localparam int NB   = DW / 8;
    localparam int NH   = DW / 16;
    localparam int NWD  = DW / 32;
    localparam int SADW = $clog2(NB * 255 + 1);

    typedef struct packed {
        logic [DW-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic            is_sub, is_gt;
    logic [DW-1:0]   sum_b, sum_h, sum_w;
    logic [NB-1:0]   eq_b, gt_b;
    logic [NH-1:0]   eq_h, gt_h;
    logic [NWD-1:0]  eq_w, gt_w;
    logic [DW-1:0]   msk_b, msk_h, msk_w;
    logic [SADW-1:0] sad;

    assign is_sub = (op_i == OP_SUB);
    assign is_gt  = (op_i == OP_CGT);

    for (genvar g = 0; g < NB; g++) begin : g_byte
        simd_lane #(.W(8), .SAT_EN(1'b1)) u_lane (
            .a_i  (src_a_i[g*8 +: 8]),
            .b_i  (src_b_i[g*8 +: 8]),
            .sub_i(is_sub),
            .sat_i(sat_i),
            .sum_o(sum_b[g*8 +: 8]),
            .eq_o (eq_b[g]),
            .gt_o (gt_b[g])
        );
    end

    for (genvar g = 0; g < NH; g++) begin : g_half
        simd_lane #(.W(16), .SAT_EN(1'b1)) u_lane (
            .a_i  (src_a_i[g*16 +: 16]),
            .b_i  (src_b_i[g*16 +: 16]),
            .sub_i(is_sub),
            .sat_i(sat_i),
            .sum_o(sum_h[g*16 +: 16]),
            .eq_o (eq_h[g]),
            .gt_o (gt_h[g])
        );
    end

    for (genvar g = 0; g < NWD; g++) begin : g_word
        simd_lane #(.W(32), .SAT_EN(1'b0)) u_lane (
            .a_i  (src_a_i[g*32 +: 32]),
            .b_i  (src_b_i[g*32 +: 32]),
            .sub_i(is_sub),
            .sat_i(sat_i),
            .sum_o(sum_w[g*32 +: 32]),
            .eq_o (eq_w[g]),
            .gt_o (gt_w[g])
        );
    end

    simd_sad #(.NB(NB), .SW(SADW)) u_sad (
        .a_i  (src_a_i),
        .b_i  (src_b_i),
        .sad_o(sad)
    );

    // Expand per-lane compare flags into full-lane masks.
    always_comb begin
        for (int k = 0; k < NB; k++)  msk_b[k*8 +: 8]   = {8{is_gt ? gt_b[k] : eq_b[k]}};
        for (int k = 0; k < NH; k++)  msk_h[k*16 +: 16] = {16{is_gt ? gt_h[k] : eq_h[k]}};
        for (int k = 0; k < NWD; k++) msk_w[k*32 +: 32] = {32{is_gt ? gt_w[k] : eq_w[k]}};
    end

    // Next-state computation.
    always_comb begin
        logic          op_ok, size_ok;
        logic [DW-1:0] sel_sum, sel_msk;

        st_d    = st_q;
        op_ok   = (op_i <= OP_SAD);
        size_ok = (lsize_i != 2'd3);

        case (lsize_i)
            LW_B:    begin sel_sum = sum_b; sel_msk = msk_b; end
            LW_H:    begin sel_sum = sum_h; sel_msk = msk_h; end
            default: begin sel_sum = sum_w; sel_msk = msk_w; end
        endcase

        if (valid_i && pred_i && op_ok && size_ok) begin
            case (op_i)
                OP_ADD, OP_SUB: st_d.res = sel_sum;
                OP_CEQ, OP_CGT: st_d.res = sel_msk;
                default:        st_d.res = {{(DW-SADW){1'b0}}, sad};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic          pred_i,
    input logic [2:0]    op_i,
    input logic [1:0]    lsize_i,
    input logic [1:0]    sat_i,
    input logic [DW-1:0] src_a_i,
    input logic [DW-1:0] src_b_i,
    input logic [DW-1:0] result_o
);
    localparam int NB   = DW / 8;
    localparam int SADW = $clog2(NB * 255 + 1);

    logic take;
    assign take = valid_i && pred_i && (op_i <= 3'd4) && (lsize_i != 2'd3);

    a_r12_reset_clear: assert property (@(posedge clk)
        !rst_n |=> result_o == '0);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && pred_i) |=> $stable(result_o));

    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_i && ((op_i > 3'd4) || (lsize_i == 2'd3))) |=> $stable(result_o));

    a_r9_sad_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_i == 3'd4) |=> result_o[DW-1:SADW] == '0);

    a_r8_gt_equal_false: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_i == 3'd3 && lsize_i == 2'd2 && src_a_i[31:0] == src_b_i[31:0])
        |=> result_o[31:0] == 32'h0);

    a_r5_uuu_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_i == 3'd0 && sat_i == 2'd3 && lsize_i == 2'd0)
        |=> result_o[7:0] >= $past(src_a_i[7:0]));

    for (genvar g = 0; g < NB; g++) begin : g_mask
        a_r7_byte_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (take && (op_i == 3'd2 || op_i == 3'd3) && lsize_i == 2'd0)
            |=> (result_o[g*8 +: 8] == 8'h00 || result_o[g*8 +: 8] == 8'hFF));
    end
endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .pred_i  (pred_i),
    .op_i    (op_i),
    .lsize_i (lsize_i),
    .sat_i   (sat_i),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .result_o(result_o)
);

// File: tb/sim_simd_alu.sv
module sim_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        pred_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  lsize_i = '0;
    logic [1:0]  sat_i = '0;
    logic [63:0] src_a_i = '0;
    logic [63:0] src_b_i = '0;
    logic [63:0] result_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] prev_exp = '0;

    always #10 clk = ~clk;

    simd_alu u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pred_i(pred_i),
        .op_i(op_i), .lsize_i(lsize_i), .sat_i(sat_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .result_o(result_o)
    );

    // Arithmetic reference per requirement.
    function automatic logic [63:0] model(input int op, input int sz, input int sat,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] res = '0;
        int n = 8 << sz;
        int lanes = 64 / n;
        longint mask = (longint'(1) << n) - 1;
        if (op == 4) begin
            longint s = 0;
            for (int k = 0; k < 8; k++) begin
                longint x = longint'(a[k*8 +: 8]);
                longint y = longint'(b[k*8 +: 8]);
                s += (x > y) ? x - y : y - x;
            end
            return 64'(s);
        end
        for (int l = 0; l < lanes; l++) begin
            longint ua = longint'((a >> (l*n))) & mask;
            longint ub = longint'((b >> (l*n))) & mask;
            longint sa = (ua > (mask >> 1)) ? ua - mask - 1 : ua;
            longint sb = (ub > (mask >> 1)) ? ub - mask - 1 : ub;
            longint r;
            if (op == 2) r = (ua == ub) ? mask : 0;
            else if (op == 3) r = (sa > sb) ? mask : 0;
            else begin
                longint ax = (sat == 1) ? sa : ua;
                longint bx = (sat == 1 || sat == 2) ? sb : ub;
                r = (op == 1) ? ax - bx : ax + bx;
                if (sat != 0 && sz != 2) begin
                    if (sat == 1) begin
                        if (r > (mask >> 1)) r = mask >> 1;
                        if (r < -(mask >> 1) - 1) r = -(mask >> 1) - 1;
                    end else begin
                        if (r < 0) r = 0;
                        if (r > mask) r = mask;
                    end
                end
            end
            res |= 64'(r & mask) << (l*n);
        end
        return res;
    endfunction

    function automatic string auto_tag(input int op, input int sz, input int sat);
        if (op == 2) return "R7";
        if (op == 3) return "R8";
        if (op == 4) return "R9";
        if (sz == 2) return "R6";
        case (sat)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R2";
        endcase
    endfunction

    // Drive at the falling edge, check at the next falling edge.
    task automatic issue(input int op, input int sz, input int sat, input logic [63:0] a,
                         input logic [63:0] b, input logic v, input logic p, input string tag);
        logic [63:0] exp;
        valid_i = v; pred_i = p; op_i = 3'(op); lsize_i = 2'(sz); sat_i = 2'(sat);
        src_a_i = a; src_b_i = b;
        if (v && p && op <= 4 && sz != 3) exp = model(op, sz, sat, a, b);
        else exp = prev_exp;
        @(negedge clk);
        checks++;
        if (result_o !== exp) begin
            errors++;
            $display("FAIL %s op=%0d sz=%0d sat=%0d a=%h b=%h actual=%h expected=%h",
                     tag, op, sz, sat, a, b, result_o, exp);
        end
        prev_exp = exp;
    endtask

    function automatic logic [63:0] pat_a(input int i);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'((i + 29*k) & 255);
        return v;
    endfunction

    function automatic logic [63:0] pat_b(input int j, input int i);
        logic [63:0] v;
        logic [7:0] seed [7] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h3C, 8'hC3};
        if (j == 7) return pat_a(i);
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = seed[j] ^ 8'(k * 17);
        return v;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        checks++;
        if (result_o !== 64'h0) begin
            errors++;
            $display("FAIL R12 reset actual=%h expected=%h", result_o, 64'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: same operands give lane-dependent results
        issue(0, 0, 0, 64'h0000_00FF_0000_00FF, 64'h0000_0001_0000_0001, 1, 1, "R1");
        issue(0, 1, 0, 64'h0000_00FF_0000_00FF, 64'h0000_0001_0000_0001, 1, 1, "R1");
        issue(0, 2, 0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1, 1, "R1");
        // R3/R4/R5 corner clamps
        issue(0, 0, 1, 64'h7F, 64'h01, 1, 1, "R3");
        issue(1, 1, 1, 64'h8000, 64'h0001, 1, 1, "R3");
        issue(0, 0, 2, 64'h80, 64'hFF, 1, 1, "R4");
        issue(0, 0, 3, 64'hFF, 64'h01, 1, 1, "R5");
        issue(0, 2, 3, 64'hFFFF_FFFF, 64'h1, 1, 1, "R6");

        // Sweeps of add/sub and compares
        for (int sat = 0; sat < 4; sat++)
            for (int op = 0; op < 2; op++)
                for (int sz = 0; sz < 3; sz++)
                    for (int i = 0; i < 256; i++)
                        for (int j = 0; j < 8; j++)
                            issue(op, sz, sat, pat_a(i), pat_b(j, i), 1, 1, auto_tag(op, sz, sat));
        for (int op = 2; op < 4; op++)
            for (int sz = 0; sz < 3; sz++)
                for (int i = 0; i < 256; i++)
                    for (int j = 0; j < 8; j++)
                        issue(op, sz, 0, pat_a(i), pat_b(j, i), 1, 1, auto_tag(op, sz, 0));
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 8; j++)
                issue(4, j % 3, j % 4, pat_a(i), pat_b(j, i), 1, 1, "R9");

        // R10: squashed writes
        issue(0, 0, 0, 64'h1234, 64'h1, 1, 0, "R10");
        issue(0, 0, 0, 64'h5678, 64'h1, 0, 1, "R10");
        // R11: reserved codes
        issue(5, 0, 0, 64'h1, 64'h1, 1, 1, "R11");
        issue(7, 1, 0, 64'h1, 64'h1, 1, 1, "R11");
        issue(0, 3, 0, 64'h1, 64'h1, 1, 1, "R11");
        issue(4, 3, 0, 64'hFF, 64'h0, 1, 1, "R11");
        // R12: reset mid-run clears
        rst_n = 1'b0;
        #1;
        checks++;
        if (result_o !== 64'h0) begin
            errors++;
            $display("FAIL R12 async clear actual=%h expected=%h", result_o, 64'h0);
        end
        prev_exp = '0;
        @(negedge clk);
        rst_n = 1'b1;
        issue(1, 0, 0, 64'h0, 64'h1, 1, 1, "R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule